// File: doc/BRIEF.md
# Dual 8-bit Event Counter

This block counts pulses on two external event pins with a pair of 8-bit up-counters, a high counter and a low counter. Each pin is brought into the system clock domain by a short synchroniser. A rising edge seen there advances the matching counter by one. One control/status byte holds the following:

- a count-up enable and a run/hold control for each counter;
- a cascade bit that chains the two counters into a single 16-bit counter;
- a sticky overflow flag for each counter.

Software reaches the block over a byte-wide bus with a 2-bit address and separate read and write strobes. Read data is combinational from the address. Register offsets:

- offset 0: control/status byte;
- offset 1: high counter;
- offset 2: low counter.

The overflow flags are guarded against accidental loss. Software can never set a flag. A flag is removed only by writing 0 to it after a read of the control/status byte has shown it as 1.

Top module: `dual_event_counter`

## Requirements
- R1: After reset the control/status byte reads 0x00 at offset 0, and both counters read 0x00 at offsets 1 (high) and 2 (low).
- R2: Control/status bits 4 (cascade), 3 (high enable), 2 (low enable), 1 (high run) and 0 (low run) are written and read back unchanged. Bit 5 always reads 0.
- R3: While a run bit is 0 (bit 1 for high, bit 0 for low), its counter is held at 0x00 and events on its pin have no effect.
- R4: When both its run bit and its enable bit (bit 3 high, bit 2 low) are 1, each rising edge on a counter's event pin adds exactly one. When the enable bit is 0, edges leave the count unchanged.
- R5: When a counter wraps from 0xFF to 0x00, its overflow flag is set: bit 7 for the high counter, bit 6 for the low counter.
- R6: Writing 1 to bit 7 or bit 6 never sets a flag. Writing 0 to a set flag with no read of offset 0 since the last write to offset 0 leaves the flag set.
- R7: A read of offset 0 that returns a flag as 1, followed by a write to offset 0 with that bit 0, clears the flag. Any write to offset 0 ends the permission granted by the read.
- R8: With bit 4 set, the low counter counts the low pin. The high counter advances by one on each low-counter wrap, when the high enable and run bits are 1, and ignores the high pin. The low flag still sets on each low wrap.
- R9: Bus writes to offsets 1 and 2 are ignored; the counters keep their values.
- R10: If a counter wraps in the same cycle that a valid software clear hits its flag, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_hi_i | input | 1 | Event pin for the high counter (asynchronous) |
| evt_lo_i | input | 1 | Event pin for the low counter (asynchronous) |
| bus_addr | input | 2 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |

## Verification
The counting path is exercised with several input patterns:

- Short bursts on each pin separately show that the two channels are independent and that each edge adds exactly one.
- Bursts with the enable bit cleared, and bursts with the run bit cleared, separate gating by enable from holding at zero.
- Runs of 256 edges drive each counter through its wrap, which exposes flag setting.
- In cascade mode, a run of 261 low edges mixed with high-pin edges shows the carry into the high counter and the high pin being ignored.

A final edge is placed so that the wrap lands in the same cycle as an armed software clear, which separates a set-wins flag from a clear-wins flag.

// File: rtl/evc_pkg.sv
// Shared constants and the control/status layout for the dual event counter.
package evc_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int SYNC_STAGES = 2;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_HI   = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_LO   = 2'd2;

    // Channel index used for per-counter vectors
    localparam int CH_LO = 0;
    localparam int CH_HI = 1;
    localparam int NUM_CH = 2;

    // Control/status byte, MSB first (bit 7 .. bit 0)
    typedef struct packed {
        logic ovf_hi;   // bit 7
        logic ovf_lo;   // bit 6
        logic spare;    // bit 5, reads 0
        logic cascade;  // bit 4
        logic en_hi;    // bit 3
        logic en_lo;    // bit 2
        logic run_hi;   // bit 1
        logic run_lo;   // bit 0
    } ctrl_t;

    localparam int CFG_W = 5;  // bits 4..0 are plain control bits
endpackage

// File: rtl/evc_edge_sync.sv
// Brings one asynchronous event pin into the clock domain through a
// SYNC_STAGES flop chain and emits a one-cycle pulse per rising edge.
// Assumes the pin stays high and low for at least two clock periods each.
module evc_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;

    // Shift the pin through the synchroniser and remember the last sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], pin_i};
            last_q  <= chain_q[SYNC_STAGES-1];
        end
    end

    assign rise_o = chain_q[SYNC_STAGES-1] & ~last_q;

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);  // R4
endmodule

// File: rtl/evc_counter.sv
// One up-counter channel. Held at zero while run_i is low; adds one per
// cycle in which inc_i is high. wrap_o flags the step from all-ones to zero.
module evc_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_q;

    // Hold at zero, or count one step per increment request
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) cnt_q <= '0;
        else if (inc_i)       cnt_q <= cnt_q + W'(1);
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = run_i & inc_i & (cnt_q == CNT_MAX);

    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_o == '0);  // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && inc_i) |=> cnt_o == $past(cnt_o) + W'(1));  // R4
    AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !inc_i) |=> $stable(cnt_o));  // R4
endmodule

// File: rtl/evc_ctrl_reg.sv
// Control/status byte. Bits 4..0 are plain read/write. Overflow flags are
// set only by hardware; a flag is cleared by a 0 written to it after a read
// of this byte returned it as 1. A hardware set beats a clear in one cycle.
module evc_ctrl_reg
    import evc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NUM_CH-1:0] ovf_set_i,
    output ctrl_t             ctrl_o
);
    logic [CFG_W-1:0]  cfg_q;
    logic [NUM_CH-1:0] flag_q;
    logic [NUM_CH-1:0] armed_q;
    logic [NUM_CH-1:0] flag_wbit;
    logic [NUM_CH-1:0] clr;

    assign flag_wbit[CH_HI] = wdata_i[7];
    assign flag_wbit[CH_LO] = wdata_i[6];
    assign clr = {NUM_CH{wr_i}} & armed_q & ~flag_wbit;

    // Plain control bits
    always_ff @(posedge clk) begin
        if (!rst_n)    cfg_q <= '0;
        else if (wr_i) cfg_q <= wdata_i[CFG_W-1:0];
    end

    // Sticky flags: set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= ovf_set_i | (flag_q & ~clr);
    end

    // Clear permission: granted by a read showing 1, consumed by any write
    always_ff @(posedge clk) begin
        if (!rst_n)    armed_q <= '0;
        else if (wr_i) armed_q <= '0;
        else if (rd_i) armed_q <= flag_q;
    end

    assign ctrl_o = '{ovf_hi: flag_q[CH_HI], ovf_lo: flag_q[CH_LO], spare: 1'b0,
                      cascade: cfg_q[4], en_hi: cfg_q[3], en_lo: cfg_q[2],
                      run_hi: cfg_q[1], run_lo: cfg_q[0]};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_flag_chk
        AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (!flag_q[c] && !ovf_set_i[c]) |=> !flag_q[c]);  // R6
        AST_CLR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[c] && !armed_q[c]) |=> flag_q[c]);  // R7
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_set_i[c] |=> flag_q[c]);  // R10
    end
endmodule

// File: rtl/dual_event_counter.sv
// Top level: two synchronised event inputs feeding two 8-bit counters, an
// optional 16-bit cascade, a control/status byte and a byte-wide bus.
// Assumes single-cycle read and write strobes and a stable address.
module dual_event_counter
    import evc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_hi_i,
    input  logic              evt_lo_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    logic [NUM_CH-1:0] pins;
    logic [NUM_CH-1:0] rise;
    logic [NUM_CH-1:0] run;
    logic [NUM_CH-1:0] inc;
    logic [NUM_CH-1:0] wrap;
    logic [DATA_W-1:0] cnt [NUM_CH];
    ctrl_t             ctrl;

    assign pins[CH_HI] = evt_hi_i;
    assign pins[CH_LO] = evt_lo_i;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_sync
        evc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .pin_i(pins[c]), .rise_o(rise[c]));
    end

    assign run[CH_HI] = ctrl.run_hi;
    assign run[CH_LO] = ctrl.run_lo;

    // Increment sources: low from its pin; high from its pin or the low carry
    always_comb begin
        inc[CH_LO] = rise[CH_LO] & ctrl.en_lo;
        inc[CH_HI] = (ctrl.cascade ? wrap[CH_LO] : rise[CH_HI]) & ctrl.en_hi;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cnt
        evc_counter #(.W(DATA_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .run_i(run[c]), .inc_i(inc[c]),
            .cnt_o(cnt[c]), .wrap_o(wrap[c]));
    end

    evc_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .rd_i(bus_rd && bus_addr == OFS_CTRL),
        .wr_i(bus_wr && bus_addr == OFS_CTRL),
        .wdata_i(bus_wdata), .ovf_set_i(wrap), .ctrl_o(ctrl));

    // Read-data multiplexer
    always_comb begin
        case (bus_addr)
            OFS_CTRL: bus_rdata = ctrl;
            OFS_HI:   bus_rdata = cnt[CH_HI];
            OFS_LO:   bus_rdata = cnt[CH_LO];
            default:  bus_rdata = '0;
        endcase
    end

    AST_CASCADE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.cascade && wrap[CH_LO] && ctrl.en_hi && ctrl.run_hi)
        |=> cnt[CH_HI] == $past(cnt[CH_HI]) + DATA_W'(1));  // R8
    AST_CASCADE_PIN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.cascade && ctrl.run_hi && !wrap[CH_LO]) |=> $stable(cnt[CH_HI]));  // R8
    AST_LOW_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        wrap[CH_LO] |=> ctrl.ovf_lo);  // R5
endmodule

// File: tb/dual_event_counter_tb_top.sv
`timescale 1ns/1ps
module dual_event_counter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_hi = 1'b0, evt_lo = 1'b0;
    logic [1:0] addr = '0;
    logic       rd = 1'b0, wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dual_event_counter dut_i (
        .clk(clk), .rst_n(rst_n), .evt_hi_i(evt_hi), .evt_lo_i(evt_lo),
        .bus_addr(addr), .bus_rd(rd), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rdata));

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic pulses(bit hi, bit lo, int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); evt_hi = hi; evt_lo = lo;
            repeat (3) @(negedge clk);
            evt_hi = 1'b0; evt_lo = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        bus_read(2'd0, d); check("R1 ctrl", d, 8'h00);
        bus_read(2'd1, d); check("R1 high", d, 8'h00);
        bus_read(2'd2, d); check("R1 low", d, 8'h00);
    endtask

    task automatic t_ctrl_rw();
        logic [7:0] d;
        bus_write(2'd0, 8'h15); bus_read(2'd0, d); check("R2 0x15", d, 8'h15);
        bus_write(2'd0, 8'h2A); bus_read(2'd0, d); check("R2 0x0A bit5 zero", d, 8'h0A);
        bus_write(2'd0, 8'h00);
    endtask

    task automatic t_hold_and_count();
        logic [7:0] d;
        bus_write(2'd0, 8'h0C);  // enables on, run bits 0
        pulses(1, 1, 5);
        bus_read(2'd1, d); check("R3 high held", d, 8'h00);
        bus_read(2'd2, d); check("R3 low held", d, 8'h00);
        bus_write(2'd0, 8'h0F);
        pulses(1, 0, 3); pulses(0, 1, 7);
        bus_read(2'd1, d); check("R4 high count", d, 8'd3);
        bus_read(2'd2, d); check("R4 low count", d, 8'd7);
        bus_write(2'd0, 8'h03);  // enables off
        pulses(1, 1, 4);
        bus_read(2'd1, d); check("R4 high disabled", d, 8'd3);
        bus_read(2'd2, d); check("R4 low disabled", d, 8'd7);
        bus_write(2'd1, 8'h55); bus_write(2'd2, 8'hAA);
        bus_read(2'd1, d); check("R9 high read-only", d, 8'd3);
        bus_read(2'd2, d); check("R9 low read-only", d, 8'd7);
    endtask

    task automatic t_flags();
        logic [7:0] d;
        bus_write(2'd0, 8'h00); bus_write(2'd0, 8'h0F);
        pulses(0, 1, 256);
        bus_write(2'd0, 8'h0F);  // 0 to flag without prior read
        bus_read(2'd0, d); check("R5/R6 low flag kept", d, 8'h4F);
        bus_read(2'd2, d); check("R5 low wrapped", d, 8'h00);
        bus_write(2'd0, 8'hCF);  // 1s to flags
        bus_read(2'd0, d); check("R6 no software set", d, 8'h4F);
        bus_write(2'd0, 8'h0F);
        bus_read(2'd0, d); check("R7 cleared after read", d, 8'h0F);
        bus_write(2'd0, 8'h0D); bus_write(2'd0, 8'h0F);
        pulses(1, 0, 256);
        bus_read(2'd0, d); check("R5 high flag", d, 8'h8F);
        bus_write(2'd0, 8'h0F);
        bus_read(2'd0, d); check("R7 high cleared", d, 8'h0F);
    endtask

    task automatic t_cascade();
        logic [7:0] d;
        bus_write(2'd0, 8'h00); bus_write(2'd0, 8'h1F);
        pulses(0, 1, 261);
        pulses(1, 0, 3);
        bus_read(2'd2, d); check("R8 low count", d, 8'd5);
        bus_read(2'd1, d); check("R8 high carry only", d, 8'd1);
        bus_read(2'd0, d); check("R8 low flag", d, 8'h5F);
        bus_write(2'd0, 8'h00);
    endtask

    task automatic t_set_wins();
        logic [7:0] d;
        bus_write(2'd0, 8'h0F);
        pulses(0, 1, 256);
        bus_read(2'd0, d); check("R5 flag before race", d, 8'h4F);
        pulses(0, 1, 255);
        bus_read(2'd2, d); check("R10 low at 0xFF", d, 8'hFF);
        bus_read(2'd0, d);  // arms the clear
        @(negedge clk); evt_lo = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); addr = 2'd0; wdata = 8'h0F; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        repeat (3) @(negedge clk); evt_lo = 1'b0;
        repeat (3) @(negedge clk);
        bus_read(2'd0, d); check("R10 set wins", d, 8'h4F);
        bus_read(2'd2, d); check("R10 low wrapped", d, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_rw();
        t_hold_and_count();
        t_flags();
        t_cascade();
        t_set_wins();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule